// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of a 6-bit digital step attenuator that is programmed through a three-wire serial link: a data line, a shift clock and a latch-enable strobe. A client hands the block a 6-bit attenuation code with a valid/ready handshake. The master then clocks the word out, most significant weight first. It holds the strobe low for the whole shift, so the attenuation does not move while bits are loaded. It then raises and drops the strobe to apply the word. All serial activity is timed from the system clock.

Every timing interval is a cycle-count parameter. The data setup before a rising shift edge, the hold after a falling edge, the clock high time, the strobe setup after the last falling edge, the strobe width and the post-update holdoff are each given their own count. At elaboration these counts are multiplied by the system clock period and compared with the link's limits:
- 10 ns data setup and data hold
- 30 ns clock high and clock low
- a shift clock of at most 10 MHz
- 10 ns strobe setup and 30 ns strobe width
- at most one update per 40 µs

An illegal set of counts stops elaboration.

A single down-counter times every phase. The handshake stays closed from acceptance until the holdoff has run out, so the update rate cannot be exceeded.

Top module: `atten_serial_master`

## Requirements
- R1: While reset is asserted, and after it is released, serClk, serData and serLatch are low and codeReady is high. An asynchronous reset in the middle of a transfer returns the block to this state at once.
- R2: A code is accepted on a clock edge where codeValid and codeReady are both high. codeReady is low from the next cycle for exactly 6*(HOLD_CYC+SETUP_CYC+HIGH_CYC)+LATCH_SETUP_CYC+LATCH_WIDTH_CYC+HOLDOFF_CYC cycles. With the default counts this is 5080 cycles.
- R3: The word is shifted with codeIn[5] (the 16 dB weight) first and codeIn[0] (the 0.5 dB weight) last. Each bit is taken by the receiver on a rising serClk edge. A receiver that shifts in at each rising edge and latches on the falling serLatch edge ends up holding exactly the accepted code.
- R4: serLatch is low while serClk toggles. Each accepted code produces exactly one serLatch pulse.
- R5: serData changes only while serClk is low. A change comes no sooner than HOLD_CYC cycles after the preceding falling serClk edge and no later than SETUP_CYC cycles before the next rising edge.
- R6: Each update produces exactly six rising serClk edges. serClk stays high for at least HIGH_CYC cycles and low for at least HOLD_CYC+SETUP_CYC cycles.
- R7: serLatch rises exactly LATCH_SETUP_CYC cycles after the last falling serClk edge and stays high for exactly LATCH_WIDTH_CYC cycles.
- R8: Successive rising serLatch edges are at least LATCH_WIDTH_CYC+HOLDOFF_CYC cycles apart. A request held valid through the holdoff is accepted on the first cycle codeReady is high, which puts its latch pulse exactly one busy period plus one cycle after the previous one.
- R9: codeValid asserted while codeReady is low is ignored. It starts no transfer, and it does not alter the word being sent or the word latched.
- R10: Whenever codeReady is high, serClk, serData and serLatch are all low. serData returns low when the latch pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every serial interval counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| codeIn | input | WORD_W | Attenuation code; bit WORD_W-1 is the largest weight |
| codeValid | input | 1 | A code is offered |
| codeReady | output | 1 | The master can take a code |
| serClk | output | 1 | Serial shift clock to the attenuator |
| serData | output | 1 | Serial data to the attenuator |
| serLatch | output | 1 | Latch-enable strobe to the attenuator |

## Verification
Two functions can land in one cycle: the holdoff counter reaching zero, and a new request being taken on the first idle cycle that follows. The bench keeps codeValid high across a whole transfer with a second code already waiting. It then expects the second acceptance exactly one busy period plus one cycle after the first. The two latch pulses must be spaced by that same amount and never closer than the rate limit. The bound checker confirms, at the same moment, that the restart does not move the data line earlier than the hold interval allows.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

  // Link limits in picoseconds
  localparam longint LIM_DATA_SETUP_PS  = 10_000;
  localparam longint LIM_DATA_HOLD_PS   = 10_000;
  localparam longint LIM_CLK_HIGH_PS    = 30_000;
  localparam longint LIM_CLK_LOW_PS     = 30_000;
  localparam longint LIM_CLK_PERIOD_PS  = 100_000;
  localparam longint LIM_LATCH_SETUP_PS = 10_000;
  localparam longint LIM_LATCH_WIDTH_PS = 30_000;
  localparam longint LIM_UPDATE_PS      = 40_000_000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_LE_SETUP,
    ST_LE_PULSE,
    ST_HOLDOFF
  } ctrlState_t;

  typedef enum logic [1:0] {
    PH_HOLD,
    PH_SETUP,
    PH_HIGH
  } bitPhase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic present;
    logic clkRise;
    logic clkFall;
    logic latchRise;
    logic latchFall;
  } dpStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/atten_ser_ctrl.sv
module atten_ser_ctrl
  import atten_ser_pkg::*;
#(
  parameter int WORD_W          = 6,
  parameter int HOLD_CYC        = 3,
  parameter int SETUP_CYC       = 3,
  parameter int HIGH_CYC        = 7,
  parameter int LATCH_SETUP_CYC = 2,
  parameter int LATCH_WIDTH_CYC = 4,
  parameter int HOLDOFF_CYC     = 4996
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      codeValid,
  output logic      codeReady,
  output dpStrobe_t strobe
);

  localparam int MAX_CNT = maxOf(maxOf(maxOf(HOLD_CYC, SETUP_CYC), maxOf(HIGH_CYC, LATCH_SETUP_CYC)),
                                 maxOf(LATCH_WIDTH_CYC, HOLDOFF_CYC));
  localparam int CNT_W = $clog2(MAX_CNT + 1);
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HIGH   = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] LD_LSETUP = CNT_W'(LATCH_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_LWIDTH = CNT_W'(LATCH_WIDTH_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOFF   = CNT_W'(HOLDOFF_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);

  ctrlState_t       state;
  bitPhase_t        phase;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitIdx;
  logic             cntDone;

  assign cntDone   = (cnt == '0);
  assign codeReady = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= PH_HOLD;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (codeValid) begin
            state  <= ST_SHIFT;
            phase  <= PH_HOLD;
            cnt    <= LD_HOLD;
            bitIdx <= '0;
          end
        end
        ST_SHIFT: begin
          if (!cntDone) begin
            cnt <= cnt - 1'b1;
          end else begin
            unique case (phase)
              PH_HOLD: begin
                phase <= PH_SETUP;
                cnt   <= LD_SETUP;
              end
              PH_SETUP: begin
                phase <= PH_HIGH;
                cnt   <= LD_HIGH;
              end
              default: begin
                if (bitIdx == LAST_BIT) begin
                  state <= ST_LE_SETUP;
                  phase <= PH_HOLD;
                  cnt   <= LD_LSETUP;
                end else begin
                  bitIdx <= bitIdx + 1'b1;
                  phase  <= PH_HOLD;
                  cnt    <= LD_HOLD;
                end
              end
            endcase
          end
        end
        ST_LE_SETUP: begin
          if (!cntDone) cnt <= cnt - 1'b1;
          else begin
            state <= ST_LE_PULSE;
            cnt   <= LD_LWIDTH;
          end
        end
        ST_LE_PULSE: begin
          if (!cntDone) cnt <= cnt - 1'b1;
          else begin
            state <= ST_HOLDOFF;
            cnt   <= LD_HOFF;
          end
        end
        default: begin
          if (!cntDone) cnt <= cnt - 1'b1;
          else state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.load      = (state == ST_IDLE) && codeValid;
    strobe.present   = (state == ST_SHIFT) && (phase == PH_HOLD)  && cntDone;
    strobe.clkRise   = (state == ST_SHIFT) && (phase == PH_SETUP) && cntDone;
    strobe.clkFall   = (state == ST_SHIFT) && (phase == PH_HIGH)  && cntDone;
    strobe.latchRise = (state == ST_LE_SETUP) && cntDone;
    strobe.latchFall = (state == ST_LE_PULSE) && cntDone;
  end

endmodule

// File: rtl/atten_ser_dp.sv
module atten_ser_dp
  import atten_ser_pkg::*;
#(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] wordIn,
  output logic              serClk,
  output logic              serData,
  output logic              serLatch
);

  logic [WORD_W-1:0] shiftReg;

  // Word register: top bit goes out first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (strobe.load) begin
      shiftReg <= wordIn;
    end else if (strobe.present) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  // Data pin: updated in the low phase, cleared when the strobe drops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serData <= 1'b0;
    end else if (strobe.present) begin
      serData <= shiftReg[WORD_W-1];
    end else if (strobe.latchFall) begin
      serData <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serClk <= 1'b0;
    end else if (strobe.clkRise) begin
      serClk <= 1'b1;
    end else if (strobe.clkFall) begin
      serClk <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serLatch <= 1'b0;
    end else if (strobe.latchRise) begin
      serLatch <= 1'b1;
    end else if (strobe.latchFall) begin
      serLatch <= 1'b0;
    end
  end

endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
  import atten_ser_pkg::*;
#(
  parameter int SYS_PERIOD_PS   = 8000,
  parameter int WORD_W          = 6,
  parameter int HOLD_CYC        = 3,
  parameter int SETUP_CYC       = 3,
  parameter int HIGH_CYC        = 7,
  parameter int LATCH_SETUP_CYC = 2,
  parameter int LATCH_WIDTH_CYC = 4,
  parameter int HOLDOFF_CYC     = 4996
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] codeIn,
  input  logic              codeValid,
  output logic              codeReady,
  output logic              serClk,
  output logic              serData,
  output logic              serLatch
);

  localparam longint PER = longint'(SYS_PERIOD_PS);
  localparam bit COUNTS_POSITIVE = (HOLD_CYC > 0) && (SETUP_CYC > 0) && (HIGH_CYC > 0) &&
                                   (LATCH_SETUP_CYC > 0) && (LATCH_WIDTH_CYC > 0) &&
                                   (HOLDOFF_CYC > 0) && (WORD_W > 1);
  localparam bit TIMING_OK =
      (longint'(HOLD_CYC) * PER >= LIM_DATA_HOLD_PS) &&
      (longint'(SETUP_CYC) * PER >= LIM_DATA_SETUP_PS) &&
      (longint'(HIGH_CYC) * PER >= LIM_CLK_HIGH_PS) &&
      (longint'(HOLD_CYC + SETUP_CYC) * PER >= LIM_CLK_LOW_PS) &&
      (longint'(HOLD_CYC + SETUP_CYC + HIGH_CYC) * PER >= LIM_CLK_PERIOD_PS) &&
      (longint'(LATCH_SETUP_CYC) * PER >= LIM_LATCH_SETUP_PS) &&
      (longint'(LATCH_WIDTH_CYC) * PER >= LIM_LATCH_WIDTH_PS) &&
      (LATCH_SETUP_CYC + LATCH_WIDTH_CYC >= HOLD_CYC) &&
      (longint'(LATCH_WIDTH_CYC + HOLDOFF_CYC) * PER >= LIM_UPDATE_PS);

  if (!(COUNTS_POSITIVE && TIMING_OK)) begin : g_bad_timing
    $error("atten_serial_master: cycle counts break the serial link limits at this clock period");
  end

  dpStrobe_t strobe;

  atten_ser_ctrl #(
    .WORD_W         (WORD_W),
    .HOLD_CYC       (HOLD_CYC),
    .SETUP_CYC      (SETUP_CYC),
    .HIGH_CYC       (HIGH_CYC),
    .LATCH_SETUP_CYC(LATCH_SETUP_CYC),
    .LATCH_WIDTH_CYC(LATCH_WIDTH_CYC),
    .HOLDOFF_CYC    (HOLDOFF_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .codeValid(codeValid),
    .codeReady(codeReady),
    .strobe   (strobe)
  );

  atten_ser_dp #(
    .WORD_W(WORD_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .wordIn  (codeIn),
    .serClk  (serClk),
    .serData (serData),
    .serLatch(serLatch)
  );

endmodule

// File: rtl/atten_ser_chk.sv
module atten_ser_chk #(
  parameter int HOLD_CYC        = 3,
  parameter int SETUP_CYC       = 3,
  parameter int HIGH_CYC        = 7,
  parameter int LATCH_SETUP_CYC = 2,
  parameter int LATCH_WIDTH_CYC = 4,
  parameter int HOLDOFF_CYC     = 4996
) (
  input logic clk,
  input logic rst_n,
  input logic codeValid,
  input logic codeReady,
  input logic serClk,
  input logic serData,
  input logic serLatch
);

  localparam int unsigned SAT = 32'h7fff_ffff;
  localparam int unsigned MIN_GAP = LATCH_WIDTH_CYC + HOLDOFF_CYC;

  function automatic int unsigned bump(input int unsigned v);
    return (v >= SAT) ? SAT : v + 1;
  endfunction

  logic        clkPrev, dataPrev, latchPrev;
  int unsigned dataAge, fallAge, highAge, latchAge, latchGap;

  // Cycle counters since the last event of each kind
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkPrev   <= 1'b0;
      dataPrev  <= 1'b0;
      latchPrev <= 1'b0;
      dataAge   <= 0;
      fallAge   <= SAT;
      highAge   <= 0;
      latchAge  <= 0;
      latchGap  <= SAT;
    end else begin
      clkPrev   <= serClk;
      dataPrev  <= serData;
      latchPrev <= serLatch;
      dataAge   <= (serData != dataPrev)      ? 1 : bump(dataAge);
      fallAge   <= (clkPrev && !serClk)       ? 1 : bump(fallAge);
      highAge   <= (!clkPrev && serClk)       ? 1 : bump(highAge);
      latchAge  <= (!latchPrev && serLatch)   ? 1 : bump(latchAge);
      latchGap  <= (!latchPrev && serLatch)   ? 1 : bump(latchGap);
    end
  end

  assert_ready_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(codeReady) |-> $past(codeValid));

  assert_latch_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    serLatch |-> !serClk);

  assert_data_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serClk) |-> dataAge >= SETUP_CYC);

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (serData != dataPrev) |-> (!serClk && fallAge >= HOLD_CYC));

  assert_clk_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(serClk) |-> highAge >= HIGH_CYC);

  assert_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serClk) |-> fallAge >= HOLD_CYC + SETUP_CYC);

  assert_latch_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serLatch) |-> fallAge >= LATCH_SETUP_CYC);

  assert_latch_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(serLatch) |-> latchAge >= LATCH_WIDTH_CYC);

  assert_update_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serLatch) |-> latchGap >= MIN_GAP);

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    codeReady |-> (!serClk && !serLatch && !serData));

endmodule

bind atten_serial_master atten_ser_chk #(
  .HOLD_CYC       (HOLD_CYC),
  .SETUP_CYC      (SETUP_CYC),
  .HIGH_CYC       (HIGH_CYC),
  .LATCH_SETUP_CYC(LATCH_SETUP_CYC),
  .LATCH_WIDTH_CYC(LATCH_WIDTH_CYC),
  .HOLDOFF_CYC    (HOLDOFF_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .codeValid(codeValid),
  .codeReady(codeReady),
  .serClk   (serClk),
  .serData  (serData),
  .serLatch (serLatch)
);

// File: tb/atten_serial_master_tb.sv
`timescale 1ns/1ps
module atten_serial_master_tb;

  localparam int HOLD   = 3;
  localparam int SETUP  = 3;
  localparam int HIGH   = 7;
  localparam int LSETUP = 2;
  localparam int LWIDTH = 4;
  localparam int HOFF   = 4996;
  localparam int BIT_T  = HOLD + SETUP + HIGH;
  localparam int BUSY   = 6 * BIT_T + LSETUP + LWIDTH + HOFF;
  localparam int LATCH_AT = 6 * BIT_T + LSETUP;
  localparam int NVEC = 8;

  localparam logic [5:0] VEC_CODE [NVEC] = '{6'h00, 6'h3F, 6'h20, 6'h01, 6'h2A, 6'h15, 6'h10, 6'h0C};
  localparam logic [5:0] VEC_EXP  [NVEC] = '{6'h00, 6'h3F, 6'h20, 6'h01, 6'h2A, 6'h15, 6'h10, 6'h0C};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] codeIn = '0;
  logic       codeValid = 1'b0;
  logic       codeReady, serClk, serData, serLatch;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  atten_serial_master #(
    .SYS_PERIOD_PS(8000), .WORD_W(6), .HOLD_CYC(HOLD), .SETUP_CYC(SETUP), .HIGH_CYC(HIGH),
    .LATCH_SETUP_CYC(LSETUP), .LATCH_WIDTH_CYC(LWIDTH), .HOLDOFF_CYC(HOFF)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .codeIn(codeIn), .codeValid(codeValid), .codeReady(codeReady),
    .serClk(serClk), .serData(serData), .serLatch(serLatch)
  );

  // Receiver model and link timing monitor, sampled on falling system edges
  logic       mClk = 1'b0, mData = 1'b0, mLatch = 1'b0;
  logic [5:0] rxShift = '0, rxLatched = '0;
  int riseCount = 0, lePulses = 0, latchDuringShift = 0, timingErr = 0;
  int lastRise = -100000, lastFall = -100000, lastDataChg = -100000;
  int leRiseCyc = -100000, leFallCyc = -100000, leGap = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (serClk && !mClk) begin
        riseCount++;
        if (serLatch) latchDuringShift++;
        if (cyc - lastDataChg < SETUP) timingErr++;
        rxShift = {rxShift[4:0], serData};
        lastRise = cyc;
      end
      if (!serClk && mClk) begin
        if (cyc - lastRise < HIGH) timingErr++;
        lastFall = cyc;
      end
      if (serData != mData) begin
        if (serClk || (cyc - lastFall < HOLD)) timingErr++;
        lastDataChg = cyc;
      end
      if (serLatch && !mLatch) begin
        lePulses++;
        if (cyc - lastFall < LSETUP) timingErr++;
        leGap = cyc - leRiseCyc;
        leRiseCyc = cyc;
      end
      if (!serLatch && mLatch) begin
        leFallCyc = cyc;
        rxLatched = rxShift;
      end
    end
    mClk = serClk;
    mData = serData;
    mLatch = serLatch;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic waitReady();
    for (int n = 0; n < 20000 && !codeReady; n++) @(negedge clk);
  endtask

  // Offer a code and return the cycle of its acceptance edge
  task automatic sendCode(input logic [5:0] code, output int acc);
    @(negedge clk);
    codeIn = code;
    codeValid = 1'b1;
    waitReady();
    @(negedge clk);
    codeValid = 1'b0;
    acc = cyc;
  endtask

  task automatic countBusy(output int busy);
    busy = 0;
    for (int n = 0; n < 20000 && !codeReady; n++) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int acc, acc2, busy, r0, p0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(!serClk && !serData && !serLatch && codeReady, "R1 reset outputs",
          {serClk, serData, serLatch, codeReady}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!serClk && !serData && !serLatch && codeReady, "R1 after release",
          {serClk, serData, serLatch, codeReady}, 1);

    for (int i = 0; i < NVEC; i++) begin
      r0 = riseCount;
      p0 = lePulses;
      sendCode(VEC_CODE[i], acc);
      check(!codeReady, "R2 ready drops after accept", codeReady, 0);
      countBusy(busy);
      check(busy == BUSY, "R2 busy length", busy, BUSY);
      check(rxLatched == VEC_EXP[i], "R3 latched word", rxLatched, VEC_EXP[i]);
      check(lePulses - p0 == 1 && latchDuringShift == 0, "R4 one pulse, quiet during shift",
            lePulses - p0 + 10 * latchDuringShift, 1);
      check(timingErr == 0, "R5 data setup/hold", timingErr, 0);
      check(riseCount - r0 == 6, "R6 six clock edges", riseCount - r0, 6);
      check(leRiseCyc - acc == LATCH_AT, "R7 latch rise position", leRiseCyc - acc, LATCH_AT);
      check(leFallCyc - leRiseCyc == LWIDTH, "R7 latch width", leFallCyc - leRiseCyc, LWIDTH);
      check(!serData && !serClk && !serLatch, "R10 idle low", {serClk, serData, serLatch}, 0);
    end

    // R9: request offered while busy must be ignored
    p0 = lePulses;
    sendCode(6'h2A, acc);
    repeat (30) @(negedge clk);
    codeIn = 6'h15;
    codeValid = 1'b1;
    repeat (3) @(negedge clk);
    codeValid = 1'b0;
    codeIn = 6'h00;
    countBusy(busy);
    check(rxLatched == 6'h2A, "R9 busy request ignored (word)", rxLatched, 6'h2A);
    r0 = riseCount;
    repeat (40) @(negedge clk);
    check(riseCount == r0 && lePulses - p0 == 1 && codeReady, "R9 no extra transfer",
          riseCount - r0 + lePulses - p0, 1);

    // R8: back-to-back, second request waiting through holdoff
    @(negedge clk);
    codeIn = 6'h07;
    codeValid = 1'b1;
    waitReady();
    @(negedge clk);
    acc = cyc;
    codeIn = 6'h38;
    @(negedge clk);
    waitReady();
    check(cyc - acc == BUSY, "R8 ready returns at holdoff end", cyc - acc, BUSY);
    @(negedge clk);
    codeValid = 1'b0;
    acc2 = cyc;
    check(acc2 - acc == BUSY + 1, "R8 restart on first idle cycle", acc2 - acc, BUSY + 1);
    check(!codeReady, "R2 ready low after restart", codeReady, 0);
    check(rxLatched == 6'h07, "R3 first back-to-back word", rxLatched, 6'h07);
    countBusy(busy);
    check(rxLatched == 6'h38, "R3 second back-to-back word", rxLatched, 6'h38);
    check(leGap == BUSY + 1 && leGap >= LWIDTH + HOFF, "R8 latch spacing", leGap, BUSY + 1);
    check(timingErr == 0, "R5 timing after restart", timingErr, 0);

    // R1: asynchronous reset mid-shift
    sendCode(6'h3F, acc);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!serClk && !serData && !serLatch && codeReady, "R1 mid-transfer reset",
          {serClk, serData, serLatch, codeReady}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    sendCode(6'h19, acc);
    countBusy(busy);
    check(rxLatched == 6'h19, "R3 word after reset", rxLatched, 6'h19);

    summary();
    $finish;
  end

endmodule